// File: doc/BRIEF.md
# Timer PWM and Trigger Output Generator

This block sits beside a timer counter and turns its overflow and compare-match pulses into a single output waveform. A two-bit trigger field selects which events matter. A mode bit then chooses between two behaviours: a one-clock pulse for each event, or a change of output level for each event. A polarity bit sets the idle level of the waveform and the direction of its pulses.

The block also holds the timer's run bit. Software sets or clears this bit through a write strobe. When auto-reload is off, the block clears the run bit by itself after an overflow, which gives one-shot operation. A write always overrides the automatic clear.

A separate general-purpose output bit is stored alongside the other fields and drives its own pin directly.

Top module: `pwm_trig_out`

## Requirements
- R1: After reset, `pwm_o`, `gpo_o` and `run_o` are all 0, and the trigger selection is 00.
- R2: On a cycle with `wr_en_i` high, `gpo_o` takes the value of `wr_gpo_i` after the clock edge; without a write it holds.
- R3: A write that leaves the run bit at 0, or that selects trigger code 00 or 11, sets `pwm_o` to `wr_pol_i` after the edge.
- R4: With trigger code 00 or 11 in effect, overflow and match pulses leave `pwm_o` unchanged.
- R5: With trigger code 01, an overflow is a trigger event and a match pulse is ignored.
- R6: With trigger code 10, both overflow and match are trigger events. When both arrive in one cycle they form a single event.
- R7: With the toggle bit at 0 (pulse mode), each trigger event drives `pwm_o` to the inverse of the polarity bit for exactly one cycle, after which it returns to the polarity level. Polarity 0 therefore gives a high pulse and polarity 1 a low pulse.
- R8: With the toggle bit at 1, each trigger event inverts `pwm_o` after the edge.
- R9: Overflow and match cause no trigger event while `run_o` is 0.
- R10: A write sets `run_o` to `wr_run_i` after the edge.
- R11: With `auto_reload_i` at 0 and `run_o` at 1, an overflow with no write clears `run_o` after the edge.
- R12: With `auto_reload_i` at 1, an overflow does not change `run_o`.
- R13: When a write and a one-shot overflow coincide, `run_o` takes `wr_run_i`.
- R14: Configuration written in a cycle (trigger, toggle, polarity) already governs the events of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_i | input | 1 | Counter overflow pulse |
| match_i | input | 1 | Compare-match pulse |
| auto_reload_i | input | 1 | 1 = counter reloads, 0 = one-shot |
| wr_en_i | input | 1 | Control write strobe |
| wr_run_i | input | 1 | Run bit to write |
| wr_trig_i | input | 2 | Trigger selection to write: 00 none, 01 overflow, 10 overflow and match, 11 none |
| wr_toggle_i | input | 1 | 0 = pulse mode, 1 = toggle mode |
| wr_pol_i | input | 1 | Polarity / idle level to write |
| wr_gpo_i | input | 1 | General-purpose output value to write |
| pwm_o | output | 1 | PWM / trigger output |
| gpo_o | output | 1 | General-purpose output |
| run_o | output | 1 | Current run bit |

## Verification
The hardest cases to reach are coincidences: a write landing in the same cycle as a one-shot overflow, and overflow and match arriving together under trigger code 10. Directed sequences set up each coincidence explicitly. A long random phase then fires overflow and match pulses with high probability, issues writes at a low rate and flips auto-reload, so these collisions also occur in mixed configurations, including right after a one-shot stop.

// File: rtl/pwm_trig_out.sv
module pwm_trig_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_i,
  input  logic       match_i,
  input  logic       auto_reload_i,
  input  logic       wr_en_i,
  input  logic       wr_run_i,
  input  logic [1:0] wr_trig_i,
  input  logic       wr_toggle_i,
  input  logic       wr_pol_i,
  input  logic       wr_gpo_i,
  output logic       pwm_o,
  output logic       gpo_o,
  output logic       run_o
);

  localparam logic [1:0] TRIG_OVF  = 2'b01;
  localparam logic [1:0] TRIG_BOTH = 2'b10;

  logic [1:0] trig_q, trig_n;
  logic       run_q, tog_q, pol_q, gpo_q, out_q;
  logic       run_n, tog_n, pol_n;
  logic       trig_on, evt, one_shot_stop;

  assign trig_n = wr_en_i ? wr_trig_i   : trig_q;
  assign tog_n  = wr_en_i ? wr_toggle_i : tog_q;
  assign pol_n  = wr_en_i ? wr_pol_i    : pol_q;

  assign one_shot_stop = run_q & ovf_i & ~auto_reload_i;
  assign run_n = wr_en_i ? wr_run_i : (one_shot_stop ? 1'b0 : run_q);

  assign trig_on = (trig_n == TRIG_OVF) || (trig_n == TRIG_BOTH);
  assign evt = run_q & trig_on & (ovf_i | (match_i & (trig_n == TRIG_BOTH)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 2'b00;
      run_q  <= 1'b0;
      tog_q  <= 1'b0;
      pol_q  <= 1'b0;
      gpo_q  <= 1'b0;
    end else begin
      trig_q <= trig_n;
      run_q  <= run_n;
      tog_q  <= tog_n;
      pol_q  <= pol_n;
      if (wr_en_i) gpo_q <= wr_gpo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               out_q <= 1'b0;
    else if (wr_en_i && (!run_n || !trig_on)) out_q <= wr_pol_i;
    else if (!trig_on)                        out_q <= out_q;
    else if (evt)                             out_q <= tog_n ? ~out_q : ~pol_n;
    else if (!tog_n)                          out_q <= pol_n;
  end

  assign pwm_o = out_q;
  assign gpo_o = gpo_q;
  assign run_o = run_q;

endmodule

module pwm_trig_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_i,
  input logic       auto_reload_i,
  input logic       wr_en_i,
  input logic       wr_run_i,
  input logic [1:0] wr_trig_i,
  input logic       wr_pol_i,
  input logic       wr_gpo_i,
  input logic       pwm_o,
  input logic       gpo_o,
  input logic       run_o
);

  a_r2_gpo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> gpo_o == $past(wr_gpo_i));

  a_r2_gpo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(gpo_o));

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (!wr_run_i || wr_trig_i == 2'b00 || wr_trig_i == 2'b11)) |=> pwm_o == $past(wr_pol_i));

  a_r10_run_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> run_o == $past(wr_run_i));

  a_r11_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && ovf_i && !auto_reload_i && !wr_en_i) |=> !run_o);

  a_r12_reload_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && auto_reload_i && !wr_en_i) |=> run_o);

endmodule

bind pwm_trig_out pwm_trig_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .auto_reload_i(auto_reload_i),
  .wr_en_i(wr_en_i), .wr_run_i(wr_run_i), .wr_trig_i(wr_trig_i),
  .wr_pol_i(wr_pol_i), .wr_gpo_i(wr_gpo_i), .pwm_o(pwm_o), .gpo_o(gpo_o),
  .run_o(run_o)
);

// File: tb/sim_pwm_trig_out.sv
`timescale 1ns/100ps
module sim_pwm_trig_out;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ovf = 0, match = 0, ar = 0, we = 0, w_run = 0, w_tog = 0, w_pol = 0, w_gpo = 0;
  logic [1:0] w_trig = 0;
  logic pwm, gpo, run;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] m_trig;
  logic m_run, m_tog, m_pol, m_gpo, m_out;

  always #2.5 clk = ~clk;

  pwm_trig_out u0 (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .match_i(match), .auto_reload_i(ar),
    .wr_en_i(we), .wr_run_i(w_run), .wr_trig_i(w_trig), .wr_toggle_i(w_tog),
    .wr_pol_i(w_pol), .wr_gpo_i(w_gpo), .pwm_o(pwm), .gpo_o(gpo), .run_o(run)
  );

  function automatic bit active(input logic [1:0] t);
    return t == 2'b01 || t == 2'b10;
  endfunction

  task automatic model_step();
    logic [1:0] t = we ? w_trig : m_trig;
    logic tg = we ? w_tog : m_tog;
    logic p  = we ? w_pol : m_pol;
    logic r  = we ? w_run : ((m_run && ovf && !ar) ? 1'b0 : m_run);
    bit ev = m_run && active(t) && (ovf || (match && t == 2'b10));
    if (we && (!r || !active(t))) m_out = w_pol;
    else if (!active(t)) m_out = m_out;
    else if (ev) m_out = tg ? ~m_out : ~p;
    else if (!tg) m_out = p;
    m_trig = t; m_tog = tg; m_pol = p; m_run = r;
    if (we) m_gpo = w_gpo;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "pwm", pwm, m_out);
    chk(tag, "gpo", gpo, m_gpo);
    chk(tag, "run", run, m_run);
    we = 0; ovf = 0; match = 0;
  endtask

  task automatic wr(input logic r, input logic [1:0] t, input logic tg, input logic p, input logic g);
    we = 1; w_run = r; w_trig = t; w_tog = tg; w_pol = p; w_gpo = g;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_trig = 0; m_run = 0; m_tog = 0; m_pol = 0; m_gpo = 0; m_out = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pwm", pwm, 1'b0);
    chk("R1", "gpo", gpo, 1'b0);
    chk("R1", "run", run, 1'b0);
    rst_n = 1;
    cyc("R1");

    wr(0, 2'b00, 0, 0, 1); cyc("R2");
    chk("R2", "gpo", gpo, 1'b1);
    wr(0, 2'b01, 0, 1, 1); cyc("R3");
    chk("R3", "pwm", pwm, 1'b1);
    wr(0, 2'b01, 0, 0, 0); cyc("R3");
    chk("R3", "pwm", pwm, 1'b0);

    ar = 1;
    wr(1, 2'b00, 0, 0, 0); cyc("R10");
    chk("R10", "run", run, 1'b1);
    ovf = 1; match = 1; cyc("R4");
    chk("R4", "pwm", pwm, 1'b0);
    wr(1, 2'b11, 1, 0, 0); cyc("R4");
    ovf = 1; cyc("R4");
    chk("R4", "pwm", pwm, 1'b0);

    wr(1, 2'b01, 0, 0, 0); cyc("R5");
    match = 1; cyc("R5");
    chk("R5", "pwm", pwm, 1'b0);
    ovf = 1; cyc("R7");
    chk("R7", "pwm", pwm, 1'b1);
    cyc("R7");
    chk("R7", "pwm", pwm, 1'b0);
    chk("R12", "run", run, 1'b1);

    wr(1, 2'b10, 0, 0, 0); cyc("R6");
    match = 1; cyc("R6");
    chk("R6", "pwm", pwm, 1'b1);
    cyc("R6");
    wr(1, 2'b10, 1, 0, 0); cyc("R8");
    ovf = 1; match = 1; cyc("R6");
    chk("R6", "pwm", pwm, 1'b1);
    ovf = 1; cyc("R8");
    chk("R8", "pwm", pwm, 1'b0);

    wr(0, 2'b10, 0, 1, 0); cyc("R3");
    chk("R3", "pwm", pwm, 1'b1);
    wr(1, 2'b10, 0, 1, 0); cyc("R7");
    ovf = 1; cyc("R7");
    chk("R7", "pwm", pwm, 1'b0);
    cyc("R7");
    chk("R7", "pwm", pwm, 1'b1);

    wr(0, 2'b10, 1, 1, 0); cyc("R9");
    ovf = 1; match = 1; cyc("R9");
    chk("R9", "pwm", pwm, 1'b1);

    wr(1, 2'b01, 0, 0, 0); cyc("R14");
    ar = 0; ovf = 1; cyc("R11");
    chk("R11", "run", run, 1'b0);
    wr(1, 2'b01, 1, 0, 0); cyc("R13");
    ovf = 1; wr(1, 2'b01, 1, 0, 0); cyc("R13");
    chk("R13", "run", run, 1'b1);
    ovf = 1; wr(1, 2'b01, 0, 0, 0); cyc("R14");
    chk("R14", "pwm", pwm, 1'b1);

    for (int i = 0; i < 5000; i++) begin
      ovf = ($urandom % 3) == 0;
      match = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) ar = $urandom;
      if (($urandom % 8) == 0)
        wr($urandom % 4 != 0, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      cyc("R6 R7 R8 R11 R13 random");
    end
    finish_run();
  end
endmodule